// File: doc/BRIEF.md
# Modulo-Schedule Loop Sequencer

This block is the control unit of a reconfigurable loop accelerator. It runs a
software-pipelined loop by broadcasting one context id per clock cycle to every
cell of the array. The cells use that id to pick a configuration word. The
sequencer does not need to know what any cell does internally.

Before a run, the host loads four values through a small register-write port: the
number of prologue contexts, the number of steady-state contexts, the number of
epilogue contexts and the pass count of the steady state. The host then pulses
`start`. The program counter advances one context per cycle through the prologue
and the steady-state body. It jumps back to the first body context until the body
has run the requested number of times. It then plays the epilogue once and raises
`done`, which a stalled host can wait on.

Context ids are contiguous. The prologue uses ids from 0 upward, the body follows
directly after the prologue, and the epilogue follows directly after the body.

Top module: `modsched_seq`

## Requirements
- R1: During and after reset, `ctx_valid`, `busy` and `done` are 0 and `ctx_id` is 0.
- R2: A write with `cfg_we`=1 stores the low bits of `cfg_wdata` into the register that `cfg_sel` selects. The codes are 0 = prologue length, 1 = body length, 2 = epilogue length and 3 = pass count. A write made while `busy` is 1 has no effect on any later run.
- R3: A `start` pulse sampled while idle makes the first context appear on the next cycle with `ctx_valid`=1. Prologue ids run 0 to P-1.
- R4: Inside one phase, `ctx_id` goes up by exactly one on each cycle.
- R5: The body issues ids P to P+B-1 and then returns to id P, so that it runs exactly N passes in total.
- R6: After the last body pass, the epilogue issues ids P+B to P+B+E-1 exactly once.
- R7: A prologue or epilogue of length zero is skipped, and no cycle is spent on it.
- R8: When N = 0 or B = 0, no body context is issued. When P, B·N and E are all zero, `done` rises on the cycle after `start` and no context is issued.
- R9: `done` rises on the cycle after the last valid context. It stays high until a `start` is accepted. `done` and `ctx_valid` are never high together.
- R10: A `start` pulse sampled while `busy` is 1 is ignored and does not disturb the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 prologue, 1 body, 2 epilogue, 3 passes) |
| cfg_wdata | input | DATA_W (8) | Write data |
| start | input | 1 | Start pulse |
| ctx_id | output | CTX_W (6) | Context id broadcast to the cells |
| ctx_valid | output | 1 | `ctx_id` is meaningful this cycle |
| busy | output | 1 | A loop is being sequenced |
| done | output | 1 | Loop finished; held until the next accepted start |

## Verification
The bench builds the block with its defaults: 4-bit lengths and an 8-bit pass count. At these widths, a run with every phase at its largest length of 15 drives the context id up to 44, which is the top of the contiguous layout. A pass count of 255 exercises the widest repeat count and the wrap logic many times in one run. Small and zero lengths then cover skipped phases, an empty body, a fully empty loop, and a start pulse and register write that land on the last busy cycle.

// File: rtl/msq_pkg.sv
package msq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRO  = 2'd1,
    PH_BODY = 2'd2,
    PH_EPI  = 2'd3
  } phase_t;

  // Phase that follows 'from', skipping every empty phase.
  // PH_IDLE as the result means the loop is finished.
  function automatic phase_t pick_next(phase_t from, logic has_pro,
                                       logic has_body, logic has_epi);
    phase_t nxt;
    nxt = PH_IDLE;
    case (from)
      PH_IDLE: begin
        if (has_pro)       nxt = PH_PRO;
        else if (has_body) nxt = PH_BODY;
        else if (has_epi)  nxt = PH_EPI;
      end
      PH_PRO: begin
        if (has_body)      nxt = PH_BODY;
        else if (has_epi)  nxt = PH_EPI;
      end
      PH_BODY: begin
        if (has_epi)       nxt = PH_EPI;
      end
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/msq_cfg_regs.sv
module msq_cfg_regs #(
  parameter int LEN_W  = 4,
  parameter int ITER_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock,
  output logic [LEN_W-1:0]  pro_len,
  output logic [LEN_W-1:0]  body_len,
  output logic [LEN_W-1:0]  epi_len,
  output logic [ITER_W-1:0] pass_cnt
);

  logic wr_ok;
  assign wr_ok = we && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pro_len  <= '0;
      body_len <= '0;
      epi_len  <= '0;
      pass_cnt <= '0;
    end else if (wr_ok) begin
      case (sel)
        2'd0:    pro_len  <= wdata[LEN_W-1:0];
        2'd1:    body_len <= wdata[LEN_W-1:0];
        2'd2:    epi_len  <= wdata[LEN_W-1:0];
        default: pass_cnt <= wdata[ITER_W-1:0];
      endcase
    end
  end

  // R2: register contents are frozen while a loop runs
  a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && we) |=> ($stable(pro_len) && $stable(body_len) &&
                      $stable(epi_len) && $stable(pass_cnt)));

endmodule

// File: rtl/msq_pc.sv
module msq_pc
  import msq_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int ITER_W = 8,
  parameter int CTX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pro_len,
  input  logic [LEN_W-1:0]  body_len,
  input  logic [LEN_W-1:0]  epi_len,
  input  logic [ITER_W-1:0] pass_cnt,
  output logic [CTX_W-1:0]  ctx_id,
  output logic              ctx_valid,
  output logic              busy,
  output logic              done
);

  phase_t            phase_q, nxt_ph;
  logic [CTX_W-1:0]  pc_q;
  logic [ITER_W-1:0] pass_q;
  logic              done_q;

  logic [CTX_W-1:0]  body_base, epi_base, end_id, entry_pc;
  logic              has_pro, has_body, has_epi;

  // named internal events
  logic start_acc, at_end, wrap_evt, leave_evt, finish_evt;

  assign body_base = CTX_W'(pro_len);
  assign epi_base  = body_base + CTX_W'(body_len);

  assign has_pro  = (pro_len != '0);
  assign has_body = (body_len != '0) && (pass_cnt != '0);
  assign has_epi  = (epi_len != '0);

  assign busy      = (phase_q != PH_IDLE);
  assign start_acc = start && !busy;

  always_comb begin
    case (phase_q)
      PH_PRO:  end_id = body_base - CTX_W'(1);
      PH_BODY: end_id = epi_base - CTX_W'(1);
      PH_EPI:  end_id = epi_base + CTX_W'(epi_len) - CTX_W'(1);
      default: end_id = '0;
    endcase
  end

  assign at_end    = busy && (pc_q == end_id);
  assign wrap_evt  = at_end && (phase_q == PH_BODY) && (pass_q > ITER_W'(1));
  assign leave_evt = at_end && !wrap_evt;

  assign nxt_ph = pick_next(start_acc ? PH_IDLE : phase_q,
                            has_pro, has_body, has_epi);
  assign finish_evt = (start_acc || leave_evt) && (nxt_ph == PH_IDLE);

  always_comb begin
    case (nxt_ph)
      PH_BODY: entry_pc = body_base;
      PH_EPI:  entry_pc = epi_base;
      default: entry_pc = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pc_q    <= '0;
      pass_q  <= '0;
      done_q  <= 1'b0;
    end else if (start_acc || leave_evt) begin
      phase_q <= nxt_ph;
      pc_q    <= entry_pc;
      done_q  <= finish_evt;
      if (nxt_ph == PH_BODY) pass_q <= pass_cnt;
    end else if (wrap_evt) begin
      pc_q   <= body_base;
      pass_q <= pass_q - ITER_W'(1);
    end else if (busy) begin
      pc_q <= pc_q + CTX_W'(1);
    end
  end

  assign ctx_id    = pc_q;
  assign ctx_valid = busy;
  assign done      = done_q;

  // R4: one step per cycle inside a phase
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |=> (ctx_id == $past(ctx_id) + CTX_W'(1)));

  // R5: a wrap returns to the first body context
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ctx_valid && ctx_id == body_base));

  // R8: the body never runs with no passes left
  a_r8_pass_live: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BODY) |-> (pass_q != '0));

  // R9: done is held until a start
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: done and valid exclusive
  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && ctx_valid));

  // R10: start while busy does not restart the sequence
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !at_end) |=> (busy && ctx_id == $past(ctx_id) + CTX_W'(1)));

  // R1: idle outputs are quiet
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid |-> (ctx_id == '0));

endmodule

// File: rtl/modsched_seq.sv
module modsched_seq #(
  parameter  int LEN_W  = 4,
  parameter  int ITER_W = 8,
  localparam int DATA_W = (LEN_W > ITER_W) ? LEN_W : ITER_W,
  localparam int CTX_W  = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              start,
  output logic [CTX_W-1:0]  ctx_id,
  output logic              ctx_valid,
  output logic              busy,
  output logic              done
);

  logic [LEN_W-1:0]  pro_len, body_len, epi_len;
  logic [ITER_W-1:0] pass_cnt;

  msq_cfg_regs #(.LEN_W(LEN_W), .ITER_W(ITER_W), .DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .lock     (busy),
    .pro_len  (pro_len),
    .body_len (body_len),
    .epi_len  (epi_len),
    .pass_cnt (pass_cnt)
  );

  msq_pc #(.LEN_W(LEN_W), .ITER_W(ITER_W), .CTX_W(CTX_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pro_len   (pro_len),
    .body_len  (body_len),
    .epi_len   (epi_len),
    .pass_cnt  (pass_cnt),
    .ctx_id    (ctx_id),
    .ctx_valid (ctx_valid),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: tb/modsched_seq_test.sv
module modsched_seq_test;

  localparam int LEN_W  = 4;
  localparam int ITER_W = 8;
  localparam int DATA_W = 8;
  localparam int CTX_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic              start = 1'b0;
  logic [CTX_W-1:0]  ctx_id;
  logic              ctx_valid, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  modsched_seq #(.LEN_W(LEN_W), .ITER_W(ITER_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .ctx_id(ctx_id),
    .ctx_valid(ctx_valid), .busy(busy), .done(done)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = DATA_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Reference: expected id list built from the requirements (R3, R5, R6, R7, R8)
  task automatic run(int p, int b, int e, int n, bit load, bit poke_last);
    int q[$];
    if (load) begin
      wr(0, p); wr(1, b); wr(2, e); wr(3, n);   // R2 register codes
    end
    for (int i = 0; i < p; i++) q.push_back(i);
    if (b != 0)
      for (int k = 0; k < n; k++)
        for (int i = 0; i < b; i++) q.push_back(p + i);
    for (int i = 0; i < e; i++) q.push_back(p + b + i);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      check("R3 valid", int'(ctx_valid), 1);
      check("R4/R5/R6 ctx_id", int'(ctx_id), q[i]);
      check("R9 done low while issuing", int'(done), 0);
      if (poke_last && i == q.size() - 1) begin
        start = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'd9;  // R10, R2
      end
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
    end
    check("R9 done after last", int'(done), 1);
    check("R9 valid low at end", int'(ctx_valid), 0);
    check("R10 not restarted", int'(busy), 0);
    repeat (3) begin
      @(negedge clk);
      check("R9 done held", int'(done), 1);
      check("R9 idle", int'(ctx_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", int'(ctx_valid), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 ctx_id", int'(ctx_id), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", int'(done), 0);

    run(3, 4, 2, 3, 1, 0);       // R3 R4 R5 R6 general case
    run(0, 2, 0, 2, 1, 0);       // R7 zero prologue and epilogue
    run(2, 5, 3, 0, 1, 0);       // R8 zero passes
    run(1, 0, 2, 4, 1, 0);       // R8 empty body
    run(0, 0, 0, 5, 1, 0);       // R8 nothing issued, done next cycle
    run(15, 15, 15, 2, 1, 0);    // widest lengths, id reaches 44
    run(1, 1, 1, 255, 1, 0);     // R5 widest pass count
    run(2, 3, 1, 2, 1, 1);       // R10 start and write on last busy cycle
    run(2, 3, 1, 2, 0, 0);       // R2 write while busy left old prologue length

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule